// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block caches completed address translations for an I/O memory management unit. Each stored entry is tagged with a 16-bit address-space identifier (ASID) and a 64-bit I/O virtual address (IOVA). For that key it keeps the translated address, the page mask and a 2-bit permission field. A lookup presents an (ASID, IOVA) pair and gets a registered hit or miss one cycle later. On a hit the stored translation comes back with it. After a successful page walk, the walker writes the result through the fill port.

The storage is 4-way set associative with 16 sets. The set is chosen by a 32-bit three-word mixing hash of the whole key, so pages of different address spaces spread across the sets. Software-driven maintenance uses the invalidation port, which works at three granularities:

- the whole cache, in one cycle;
- one ASID, as a sweep that visits one set per cycle while `busy` is high;
- one exact key, in one cycle.

Top module: `iotlb_cache`

## Requirements
- R1: A lookup hits only when a valid entry's ASID and IOVA both equal the presented pair. The response appears on the clock edge after the lookup: `rsp_valid` is high, and on a hit `rsp_hit` is high with the stored address, mask and permission. On a miss those three outputs are zero.
- R2: The set of a key is the low 4 bits of a hash. Three 32-bit words start at 0xDEADBEEF + 16. The ASID is added to the first word, IOVA[31:0] to the second and IOVA[63:32] to the third. Six mix rounds then run with rotations 4, 6, 8, 16, 19, 4, followed by seven final rounds with rotations 14, 11, 25, 16, 4, 14, 24. The third word is the hash.
- R3: A fill whose key is absent goes to the way named by the set's round-robin pointer, whatever that way holds, and the pointer then advances by one modulo 4. A fill whose key is already present overwrites that way and leaves the pointer unchanged.
- R4: `inv_op` = 0 removes every entry in one cycle. `inv_op` = 3 changes nothing.
- R5: `inv_op` = 1 removes every entry whose ASID equals `inv_asid`, whatever its IOVA. `busy` is high for exactly 16 cycles, starting on the edge after the command.
- R6: `inv_op` = 2 removes only the entry whose ASID and IOVA both equal `inv_asid` and `inv_iova`. Entries that match on one field only stay.
- R7: While `busy` is high, lookups return miss, invalidation commands are ignored, and fills carrying the ASID being swept are dropped. Fills carrying any other ASID are stored.
- R8: A fill is dropped when an accepted invalidation in the same cycle covers its key. An invalidate-all always covers it, an ASID invalidation covers it when the ASIDs are equal, and an exact-key invalidation covers it when both fields are equal.
- R9: While `rst_n` is low the cache is emptied, all round-robin pointers return to way 0, and `busy`, `rsp_valid` and `rsp_hit` are low.
- R10: A lookup sees the contents as they were before any fill or invalidation accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 16 | Lookup ASID |
| lk_iova | input | 64 | Lookup IOVA |
| rsp_valid | output | 1 | Response for last cycle's lookup |
| rsp_hit | output | 1 | Lookup hit |
| rsp_addr | output | 64 | Translated address on hit |
| rsp_mask | output | 64 | Page mask on hit |
| rsp_perm | output | 2 | Permission bits on hit |
| fill_valid | input | 1 | Write an entry |
| fill_asid | input | 16 | Fill ASID |
| fill_iova | input | 64 | Fill IOVA |
| fill_addr | input | 64 | Fill translated address |
| fill_mask | input | 64 | Fill page mask |
| fill_perm | input | 2 | Fill permission bits |
| inv_valid | input | 1 | Invalidation command |
| inv_op | input | 2 | 0 all, 1 by ASID, 2 exact key, 3 none |
| inv_asid | input | 16 | Invalidation ASID |
| inv_iova | input | 64 | Invalidation IOVA |
| busy | output | 1 | ASID sweep in progress |

## Verification
The bench drives keys that all hash to one set. A wrong hash or a wrong replacement pointer then evicts the wrong entry, and later lookups of survivors miss or stale keys still hit. Exact-key invalidations are sent with only one field matching, which catches a design that compares the ASID alone or the IOVA alone. During a sweep the bench issues lookups, a fill for the swept ASID, a fill for another ASID and an invalidate-all. A design that answers hits while busy, keeps the swept-ASID fill or obeys the ignored command ends up with the wrong survivors. Fills collide with each kind of invalidation, and a lookup shares a cycle with a removal; a design that orders these updates wrongly keeps dead entries or reports them too early.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
  localparam int ASID_W = 16;
  localparam int VA_W   = 64;
  localparam int PA_W   = 64;
  localparam int PERM_W = 2;
  localparam logic [31:0] HASH_SEED = 32'hdeadbeef + 32'd16;

  typedef enum logic [1:0] {
    INV_ALL  = 2'd0,
    INV_ASID = 2'd1,
    INV_KEY  = 2'd2,
    INV_NOP  = 2'd3
  } inv_op_e;

  typedef struct packed {
    logic [ASID_W-1:0] asid;
    logic [VA_W-1:0]   iova;
  } key_t;

  typedef struct packed {
    logic [PA_W-1:0]   addr;
    logic [VA_W-1:0]   mask;
    logic [PERM_W-1:0] perm;
  } xlat_t;

  function automatic logic [31:0] rotl(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  // three-word mixing hash of the full key; the third word is the result
  function automatic logic [31:0] key_hash(input key_t k);
    logic [31:0] a, b, c;
    a = HASH_SEED + 32'(k.asid);
    b = HASH_SEED + k.iova[31:0];
    c = HASH_SEED + k.iova[63:32];
    a = a - c; a = a ^ rotl(c, 4);  c = c + b;
    b = b - a; b = b ^ rotl(a, 6);  a = a + c;
    c = c - b; c = c ^ rotl(b, 8);  b = b + a;
    a = a - c; a = a ^ rotl(c, 16); c = c + b;
    b = b - a; b = b ^ rotl(a, 19); a = a + c;
    c = c - b; c = c ^ rotl(b, 4);  b = b + a;
    c = c ^ b; c = c - rotl(b, 14);
    a = a ^ c; a = a - rotl(c, 11);
    b = b ^ a; b = b - rotl(a, 25);
    c = c ^ b; c = c - rotl(b, 16);
    a = a ^ c; a = a - rotl(c, 4);
    b = b ^ a; b = b - rotl(a, 14);
    c = c ^ b; c = c - rotl(b, 24);
    return c;
  endfunction
endpackage

// File: rtl/iotlb_set_index.sv
module iotlb_set_index
  import iotlb_pkg::*;
#(
  parameter int SETS = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  key_t             key,
  output logic [IDX_W-1:0] idx
);
  logic [31:0] h;
  assign h   = key_hash(key);
  assign idx = h[IDX_W-1:0];
endmodule

// File: rtl/iotlb_sweep.sv
module iotlb_sweep
  import iotlb_pkg::*;
#(
  parameter int SETS = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ASID_W-1:0] start_asid,
  output logic              busy,
  output logic [IDX_W-1:0]  idx,
  output logic [ASID_W-1:0] asid
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SETS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      asid <= '0;
    end else if (busy) begin
      if (idx == LAST) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
      asid <= start_asid;
    end
  end
endmodule

// File: rtl/iotlb_cache.sv
module iotlb_cache
  import iotlb_pkg::*;
#(
  parameter int SETS = 16,
  parameter int WAYS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VA_W-1:0]   lk_iova,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_addr,
  output logic [VA_W-1:0]   rsp_mask,
  output logic [PERM_W-1:0] rsp_perm,
  input  logic              fill_valid,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [VA_W-1:0]   fill_iova,
  input  logic [PA_W-1:0]   fill_addr,
  input  logic [VA_W-1:0]   fill_mask,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              inv_valid,
  input  logic [1:0]        inv_op,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic [VA_W-1:0]   inv_iova,
  output logic              busy
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int OCC_W = $clog2(SETS * WAYS + 1);

  logic [WAYS-1:0]  v_q   [SETS];
  key_t             key_q [SETS][WAYS];
  xlat_t            dat_q [SETS][WAYS];
  logic [WAY_W-1:0] rr_q  [SETS];

  key_t lk_key, fill_key, inv_key;
  assign lk_key   = {lk_asid, lk_iova};
  assign fill_key = {fill_asid, fill_iova};
  assign inv_key  = {inv_asid, inv_iova};

  logic [IDX_W-1:0] lk_idx, fill_idx, inv_idx;
  iotlb_set_index #(.SETS(SETS)) u_lk_idx   (.key(lk_key),   .idx(lk_idx));
  iotlb_set_index #(.SETS(SETS)) u_fill_idx (.key(fill_key), .idx(fill_idx));
  iotlb_set_index #(.SETS(SETS)) u_inv_idx  (.key(inv_key),  .idx(inv_idx));

  // command decode; nothing is accepted during a sweep
  inv_op_e op;
  logic inv_go, inv_all_go, inv_asid_go, inv_key_go;
  assign op          = inv_op_e'(inv_op);
  assign inv_go      = inv_valid && !busy;
  assign inv_all_go  = inv_go && (op == INV_ALL);
  assign inv_asid_go = inv_go && (op == INV_ASID);
  assign inv_key_go  = inv_go && (op == INV_KEY);

  logic              sweep_busy;
  logic [IDX_W-1:0]  sweep_idx;
  logic [ASID_W-1:0] sweep_asid;
  iotlb_sweep #(.SETS(SETS)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(inv_asid_go), .start_asid(inv_asid),
    .busy(sweep_busy), .idx(sweep_idx), .asid(sweep_asid)
  );
  assign busy = sweep_busy;

  // per-way tag comparisons for the four users of the array
  logic [WAYS-1:0] lk_match, fill_match, inv_match, sweep_match;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_match[w]    = v_q[lk_idx][w]   && (key_q[lk_idx][w] == lk_key);
      fill_match[w]  = v_q[fill_idx][w] && (key_q[fill_idx][w] == fill_key);
      inv_match[w]   = v_q[inv_idx][w]  && (key_q[inv_idx][w] == inv_key);
      sweep_match[w] = v_q[sweep_idx][w] && (key_q[sweep_idx][w].asid == sweep_asid);
    end
  end

  xlat_t lk_data;
  always_comb begin
    lk_data = '0;
    for (int w = 0; w < WAYS; w++)
      if (lk_match[w]) lk_data = lk_data | dat_q[lk_idx][w];
  end

  logic [WAY_W-1:0] fill_way;
  logic             fill_present;
  always_comb begin
    fill_way = rr_q[fill_idx];
    for (int w = 0; w < WAYS; w++)
      if (fill_match[w]) fill_way = WAY_W'(w);
  end
  assign fill_present = |fill_match;

  logic fill_clash, fill_go;
  assign fill_clash = inv_all_go
                   || (inv_asid_go && (inv_asid == fill_asid))
                   || (inv_key_go && (inv_key == fill_key))
                   || (sweep_busy && (fill_asid == sweep_asid));
  assign fill_go = fill_valid && !fill_clash;

  logic [OCC_W-1:0] occ;
  always_comb begin
    occ = '0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        occ = occ + OCC_W'(v_q[s][w]);
  end

  logic  rsp_valid_q, rsp_hit_q;
  xlat_t rsp_data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        v_q[s]  <= '0;
        rr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          key_q[s][w] <= '0;
          dat_q[s][w] <= '0;
        end
      end
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= lk_valid;
      rsp_hit_q   <= lk_valid && !sweep_busy && (|lk_match);
      rsp_data_q  <= (lk_valid && !sweep_busy) ? lk_data : '0;
      if (inv_all_go)
        for (int s = 0; s < SETS; s++) v_q[s] <= '0;
      if (inv_key_go)
        v_q[inv_idx] <= v_q[inv_idx] & ~inv_match;
      if (sweep_busy)
        v_q[sweep_idx] <= v_q[sweep_idx] & ~sweep_match;
      if (fill_go) begin
        v_q[fill_idx][fill_way]   <= 1'b1;
        key_q[fill_idx][fill_way] <= fill_key;
        dat_q[fill_idx][fill_way] <= '{addr: fill_addr, mask: fill_mask, perm: fill_perm};
        if (!fill_present)
          rr_q[fill_idx] <= (rr_q[fill_idx] == WAY_W'(WAYS - 1)) ? '0 : rr_q[fill_idx] + 1'b1;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_addr  = rsp_data_q.addr;
  assign rsp_mask  = rsp_data_q.mask;
  assign rsp_perm  = rsp_data_q.perm;
endmodule

// File: rtl/iotlb_cache_chk.sv
module iotlb_cache_chk #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int OCC_W = $clog2(SETS * WAYS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             busy,
  input logic [WAYS-1:0]  lk_match,
  input logic             inv_all_go,
  input logic             inv_asid_go,
  input logic [IDX_W-1:0] sweep_idx,
  input logic [OCC_W-1:0] occ
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SETS - 1);

  // R1
  one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  // R1
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  // R4
  all_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all_go |=> (occ == '0));

  // R5
  sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_asid_go |=> busy);

  // R5
  sweep_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(sweep_idx) == LAST));

  // R7
  busy_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && busy) |=> !rsp_hit);
endmodule

bind iotlb_cache iotlb_cache_chk #(.SETS(SETS), .WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .busy(busy), .lk_match(lk_match),
  .inv_all_go(inv_all_go), .inv_asid_go(inv_asid_go),
  .sweep_idx(sweep_idx), .occ(occ)
);

// File: tb/iotlb_cache_bench.sv
module iotlb_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 16;
  localparam int WAYS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, fill_valid = 0, inv_valid = 0;
  logic [15:0] lk_asid = 0, fill_asid = 0, inv_asid = 0;
  logic [63:0] lk_iova = 0, fill_iova = 0, inv_iova = 0, fill_addr = 0, fill_mask = 0;
  logic [1:0]  fill_perm = 0, inv_op = 0;
  logic rsp_valid, rsp_hit, busy;
  logic [63:0] rsp_addr, rsp_mask;
  logic [1:0]  rsp_perm;

  always #(CLK_PERIOD/2) clk = ~clk;

  iotlb_cache #(.SETS(SETS), .WAYS(WAYS)) u_iotlb_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_iova(lk_iova),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
    .rsp_mask(rsp_mask), .rsp_perm(rsp_perm),
    .fill_valid(fill_valid), .fill_asid(fill_asid), .fill_iova(fill_iova),
    .fill_addr(fill_addr), .fill_mask(fill_mask), .fill_perm(fill_perm),
    .inv_valid(inv_valid), .inv_op(inv_op), .inv_asid(inv_asid),
    .inv_iova(inv_iova), .busy(busy)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // reference contents: slots per set plus a rotating victim number
  bit          m_v    [SETS][WAYS];
  logic [15:0] m_asid [SETS][WAYS];
  logic [63:0] m_iova [SETS][WAYS];
  logic [63:0] m_addr [SETS][WAYS];
  logic [63:0] m_mask [SETS][WAYS];
  logic [1:0]  m_perm [SETS][WAYS];
  int          m_next [SETS];
  int          m_busy_left = 0;
  logic [15:0] m_sweep_asid = 0;

  function automatic int unsigned rotl(input int unsigned v, input int unsigned n);
    return (v << n) | (v >> (32 - n));
  endfunction

  // set selection written as role-rotating rounds (R2)
  function automatic int ref_set(input logic [15:0] a, input logic [63:0] va);
    int unsigned w[3];
    int unsigned mix_rot[6] = '{4, 6, 8, 16, 19, 4};
    int unsigned fin_rot[7] = '{14, 11, 25, 16, 4, 14, 24};
    int unsigned seed = 32'hdeadbeef + 32'd16;
    w[0] = seed + 32'(a);
    w[1] = seed + va[31:0];
    w[2] = seed + va[63:32];
    for (int i = 0; i < 6; i++) begin
      int x = i % 3;
      int y = (i + 1) % 3;
      int z = (i + 2) % 3;
      w[x] = w[x] - w[z];
      w[x] = w[x] ^ rotl(w[z], mix_rot[i]);
      w[z] = w[z] + w[y];
    end
    for (int i = 0; i < 7; i++) begin
      int t = (i + 2) % 3;
      int s = (i + 1) % 3;
      w[t] = w[t] ^ w[s];
      w[t] = w[t] - rotl(w[s], fin_rot[i]);
    end
    return int'(w[2] % SETS);
  endfunction

  task automatic model_clear();
    for (int s = 0; s < SETS; s++) begin
      m_next[s] = 0;
      for (int w = 0; w < WAYS; w++) m_v[s][w] = 0;
    end
    m_busy_left = 0;
  endtask

  task automatic check(input bit ok, input string tag, input logic [132:0] act, input logic [132:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic lk(input logic [15:0] a, input logic [63:0] va);
    lk_valid = 1; lk_asid = a; lk_iova = va;
  endtask

  task automatic fl(input logic [15:0] a, input logic [63:0] va, input logic [63:0] pa, input logic [1:0] p);
    fill_valid = 1; fill_asid = a; fill_iova = va;
    fill_addr = pa; fill_mask = 64'hfff; fill_perm = p;
  endtask

  task automatic iv(input logic [1:0] op, input logic [15:0] a, input logic [63:0] va);
    inv_valid = 1; inv_op = op; inv_asid = a; inv_iova = va;
  endtask

  // one clock: predict from the reference, advance it, compare after the edge
  task automatic tick(input string tag);
    bit cur_busy, hit, inv_ok, drop, found;
    logic [63:0] ea, em;
    logic [1:0] ep;
    logic [132:0] act, exp;
    int s;
    cur_busy = (m_busy_left > 0);
    hit = 0; ea = 0; em = 0; ep = 0;
    if (lk_valid && !cur_busy) begin
      s = ref_set(lk_asid, lk_iova);
      for (int w = 0; w < WAYS; w++)
        if (m_v[s][w] && m_asid[s][w] == lk_asid && m_iova[s][w] == lk_iova) begin
          hit = 1; ea = m_addr[s][w]; em = m_mask[s][w]; ep = m_perm[s][w];
        end
    end
    inv_ok = inv_valid && !cur_busy && inv_op != 2'd3;
    drop = (cur_busy && fill_asid == m_sweep_asid)
        || (inv_ok && inv_op == 2'd0)
        || (inv_ok && inv_op == 2'd1 && inv_asid == fill_asid)
        || (inv_ok && inv_op == 2'd2 && inv_asid == fill_asid && inv_iova == fill_iova);
    if (inv_ok) begin
      for (int a = 0; a < SETS; a++)
        for (int w = 0; w < WAYS; w++) begin
          if (inv_op == 2'd0) m_v[a][w] = 0;
          if (inv_op == 2'd1 && m_asid[a][w] == inv_asid) m_v[a][w] = 0;
          if (inv_op == 2'd2 && m_asid[a][w] == inv_asid && m_iova[a][w] == inv_iova) m_v[a][w] = 0;
        end
    end
    if (fill_valid && !drop) begin
      int slot;
      s = ref_set(fill_asid, fill_iova);
      found = 0; slot = m_next[s];
      for (int w = 0; w < WAYS; w++)
        if (m_v[s][w] && m_asid[s][w] == fill_asid && m_iova[s][w] == fill_iova) begin
          found = 1; slot = w;
        end
      if (!found) m_next[s] = (m_next[s] + 1) % WAYS;
      m_v[s][slot] = 1; m_asid[s][slot] = fill_asid; m_iova[s][slot] = fill_iova;
      m_addr[s][slot] = fill_addr; m_mask[s][slot] = fill_mask; m_perm[s][slot] = fill_perm;
    end
    if (cur_busy) m_busy_left--;
    if (inv_ok && inv_op == 2'd1) begin
      m_busy_left = SETS;
      m_sweep_asid = inv_asid;
    end
    exp = {lk_valid, hit, ea, em, ep, (m_busy_left > 0)};
    @(posedge clk);
    #1;
    act = {rsp_valid, rsp_hit, rsp_addr, rsp_mask, rsp_perm, busy};
    check(act === exp, tag, act, exp);
    @(negedge clk);
    lk_valid = 0; fill_valid = 0; inv_valid = 0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    model_clear();
    rst_n = 1;
    #1;
    check({rsp_valid, rsp_hit, busy} === 3'b000, "R9", {130'b0, rsp_valid, rsp_hit, busy}, 133'b0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] same [6];
    int cnt, tgt;
    model_clear();
    apply_reset();
    // R9 fresh cache misses
    lk(16'd1, 64'h1000); tick("R9");

    // R1 exact two-part match
    fl(16'd1, 64'h1000, 64'h8000_1000, 2'b01); tick("R1");
    fl(16'd2, 64'h1000, 64'h9000_1000, 2'b11); tick("R1");
    lk(16'd1, 64'h1000); tick("R1");
    lk(16'd2, 64'h1000); tick("R1");
    lk(16'd1, 64'h2000); tick("R1");
    lk(16'd3, 64'h1000); tick("R1");

    // R2 R3: six keys of ASID 7 that land in one set
    cnt = 0;
    tgt = ref_set(16'd7, 64'h10_0000);
    for (int k = 0; k < 4096 && cnt < 6; k++) begin
      logic [63:0] va = 64'h10_0000 + 64'(k) * 64'h1000;
      if (ref_set(16'd7, va) == tgt) begin
        same[cnt] = va; cnt++;
      end
    end
    for (int i = 0; i < 5; i++) begin
      fl(16'd7, same[i], 64'hA000_0000 + 64'(i), 2'b10); tick("R3");
    end
    for (int i = 0; i < 5; i++) begin
      lk(16'd7, same[i]); tick("R2");
    end
    fl(16'd7, same[3], 64'hBEEF_0000, 2'b01); tick("R3");
    fl(16'd7, same[5], 64'hA000_0005, 2'b11); tick("R3");
    for (int i = 0; i < 6; i++) begin
      lk(16'd7, same[i]); tick("R3");
    end

    // R10 lookup beside removal, then R6 exact-key removal
    lk(16'd7, same[3]); iv(2'd2, 16'd7, same[3]); tick("R10");
    lk(16'd7, same[3]); tick("R6");
    iv(2'd2, 16'd7, 64'h1000); tick("R6");
    iv(2'd2, 16'd1, same[4]); tick("R6");
    lk(16'd7, same[4]); tick("R6");
    lk(16'd1, 64'h1000); tick("R6");

    // R5 R7 ASID sweep
    fl(16'd2, 64'h5000, 64'hC000_5000, 2'b01); tick("R5");
    iv(2'd1, 16'd7, 64'h0); lk(16'd7, same[4]); tick("R5");
    lk(16'd1, 64'h1000); tick("R7");
    fl(16'd7, 64'h7_7000, 64'hD000_0000, 2'b11); tick("R7");
    fl(16'd2, 64'h6000, 64'hC000_6000, 2'b10); tick("R7");
    iv(2'd0, 16'd0, 64'h0); tick("R7");
    iv(2'd1, 16'd1, 64'h0); tick("R7");
    for (int i = 0; i < 12; i++) begin
      lk(16'd2, 64'h5000); tick("R7");
    end
    lk(16'd7, same[4]); tick("R5");
    lk(16'd7, 64'h7_7000); tick("R7");
    lk(16'd1, 64'h1000); tick("R7");
    lk(16'd2, 64'h6000); tick("R7");
    lk(16'd2, 64'h5000); tick("R5");

    // R8 fill colliding with each invalidation kind
    fl(16'd3, 64'hA000, 64'h1, 2'b01); iv(2'd2, 16'd3, 64'hA000); tick("R8");
    lk(16'd3, 64'hA000); tick("R8");
    fl(16'd3, 64'hB000, 64'h2, 2'b01); iv(2'd2, 16'd3, 64'hA000); tick("R8");
    lk(16'd3, 64'hB000); tick("R8");
    fl(16'd4, 64'hC000, 64'h3, 2'b01); iv(2'd1, 16'd4, 64'h0); tick("R8");
    for (int i = 0; i < SETS; i++) begin
      lk(16'd4, 64'hC000); tick("R8");
    end
    lk(16'd4, 64'hC000); tick("R8");

    // R4 no-op code, then flush everything with a same-cycle lookup
    iv(2'd3, 16'd3, 64'hB000); tick("R4");
    lk(16'd3, 64'hB000); tick("R4");
    fl(16'd5, 64'hD000, 64'h4, 2'b11); lk(16'd3, 64'hB000); iv(2'd0, 16'd0, 64'h0); tick("R10");
    lk(16'd3, 64'hB000); tick("R4");
    lk(16'd5, 64'hD000); tick("R4");
    lk(16'd1, 64'h1000); tick("R4");

    // R1 mixed traffic over a small key pool
    for (int n = 0; n < 800; n++) begin
      if ($urandom % 10 < 8) lk(16'(1 + $urandom % 3), 64'h4000_0000 + 64'($urandom % 10) * 64'h1000);
      if ($urandom % 10 < 4) fl(16'(1 + $urandom % 3), 64'h4000_0000 + 64'($urandom % 10) * 64'h1000,
                                64'($urandom), 2'($urandom));
      if ($urandom % 100 < 6) iv(2'($urandom % 4), 16'(1 + $urandom % 3),
                                 64'h4000_0000 + 64'($urandom % 10) * 64'h1000);
      tick("R1");
    end

    // R9 reset in mid-run
    fl(16'd6, 64'hE000, 64'h5, 2'b01); tick("R9");
    apply_reset();
    lk(16'd6, 64'hE000); tick("R9");
    finish_run();
  end
endmodule